// File: doc/BRIEF.md
# Cache Line Maintenance by Address

This block carries out one maintenance action on a single cache line chosen by its physical address. Software first programs a line-command register. This register holds an operation code and a bit that marks the supplied address as physical. Software then writes the target address, with a start bit set, into a search-address register. The block reads both ways of the set that the address selects from an external tag store. It compares the stored tags against the address tag and applies one of three update rules to the way that matches.

When a matched line holds modified data and the rule calls for it, the block raises a write-back request. That request names the line address and the way, and it stays up until the data path acknowledges it. The block then writes the new valid and modified bits back to the tag store and drops the start bit. Software polls the start bit to learn that the command has completed. Whole-cache sweeps, refill and the data arrays are handled elsewhere. The tag store is a synchronous memory outside this block.

Top module: `ccm_line_maint`

## Requirements
- R1: After reset both registers read as zero, and `tag_wr_en`, `tag_rd_en` and `wb_req` are low.
- R2: The line-command register (`csr_sel`=0) holds the operation in bits [1:0] and the physical-select flag in bit 8. The operation codes are 0 none, 1 invalidate, 2 push and 3 clear. Other bits read as zero. The register keeps its value across commands and changes only when it is written again. Writes to it are ignored while a command is busy.
- R3: The search-address register (`csr_sel`=1) takes the address in bits [31:4] and the start bit in bit 0. Address bits [3:0] are dropped and read back as zero. A write with bit 0 set starts a command. The start bit reads 1 from the cycle after that write until the command completes, and it then clears by itself. Writes to this register while the start bit reads 1 are ignored.
- R4: The set index is address bits [11:4] and the tag is bits [31:12]. Both ways of the set are read. Way w's entry sits at `tag_rd_data[w*22 +: 22]` as {valid, modified, tag[19:0]}. A way matches only when it is valid and its tag is equal to the address tag. If both ways match, way 0 is used.
- R5: Invalidate clears the valid and modified bits of the matched way and makes no write-back.
- R6: Push on a matched, modified way issues a write-back and then clears only the modified bit. Push on a matched, unmodified way issues no write-back and leaves the entry as it was.
- R7: Clear on a matched, modified way issues a write-back and then clears both bits. Clear on a matched, unmodified way issues no write-back and only clears the valid bit.
- R8: A miss, operation code 0, or a physical-select flag of 0 completes the command with no tag write and no write-back.
- R9: `wb_req` stays high, with `wb_addr` (the line-aligned address) and `wb_way` held steady, until `wb_ack` is seen. The tag write and the clearing of the start bit both come only after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_wr | input | 1 | Register write strobe |
| csr_sel | input | 1 | Register select: 0 line command, 1 search address |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Read data of the selected register |
| tag_rd_en | output | 1 | Tag store read enable |
| tag_rd_idx | output | 8 | Tag store read set index |
| tag_rd_data | input | 44 | Both ways' entries, returned one cycle after the read |
| tag_wr_en | output | 1 | Tag store write enable |
| tag_wr_idx | output | 8 | Tag store write set index |
| tag_wr_way | output | 1 | Tag store write way |
| tag_wr_valid | output | 1 | New valid bit |
| tag_wr_dirty | output | 1 | New modified bit |
| wb_req | output | 1 | Write-back request |
| wb_addr | output | 32 | Line-aligned address of the line to write back |
| wb_way | output | 1 | Way holding the line to write back |
| wb_ack | input | 1 | Write-back acknowledge |

## Verification
A wrong decision in the lookup or the update rules shows up at the tag write port within a few cycles of the start write. It appears as a wrong way, a wrong valid or modified bit, or a write that should not happen. The same kind of fault can also show as a write-back request for a clean line, or a missing request for a dirty one. A fault in the busy logic shows up in two places. One is the search-address read-back, which holds a changed address after a write that should have been ignored. The other is the start bit, which stays set or clears before the acknowledge. Every command therefore ends with the start bit polled to zero, both event queues empty, and both entries of the set compared with the values the rules predict.

// File: rtl/ccm_pkg.sv
package ccm_pkg;

   typedef enum logic [1:0] {
      LC_NONE  = 2'd0,
      LC_INVAL = 2'd1,
      LC_PUSH  = 2'd2,
      LC_CLEAR = 2'd3
   } lcmd_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_READ,
      S_CMP,
      S_WB,
      S_UPD
   } seq_e;

   typedef struct packed {
      logic wr;     // tag store update needed
      logic wb;     // write-back needed first
      logic nv;     // new valid bit
      logic nm;     // new modified bit
   } act_t;

   function automatic act_t decide(input lcmd_e op, input logic dirty);
      act_t a;
      a = '0;
      unique case (op)
         LC_INVAL: begin a.wr = 1'b1; a.wb = 1'b0;  a.nv = 1'b0; a.nm = 1'b0; end
         LC_PUSH:  begin a.wr = 1'b1; a.wb = dirty; a.nv = 1'b1; a.nm = 1'b0; end
         LC_CLEAR: begin a.wr = 1'b1; a.wb = dirty; a.nv = 1'b0; a.nm = 1'b0; end
         default:  a = '0;
      endcase
      return a;
   endfunction

endpackage

// File: rtl/ccm_regs.sv
module ccm_regs
   import ccm_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    csr_wr,
   input  logic                    csr_sel,
   input  logic [ADDR_W-1:0]       csr_wdata,
   input  logic                    done,
   output lcmd_e                   cmd,
   output logic                    phys,
   output logic [ADDR_W-1:OFF_W]   line_addr,
   output logic                    go,
   output logic                    start,
   output logic [ADDR_W-1:0]       csr_rdata
);
   localparam int PHYS_POS = 8;

   if (ADDR_W <= PHYS_POS + 1) begin : g_bad_addr
      $error("ccm_regs: ADDR_W too small for register layout");
   end
   if (OFF_W < 2) begin : g_bad_off
      $error("ccm_regs: line offset must be at least 2 bits");
   end

   logic wr_lc, wr_sa;
   logic unused_bits;

   assign wr_lc = csr_wr && !csr_sel && !go;
   assign wr_sa = csr_wr &&  csr_sel && !go;
   assign start = wr_sa && csr_wdata[0];
   assign unused_bits = ^{csr_wdata[OFF_W-1:1], csr_wdata[PHYS_POS-1:2],
                          csr_wdata[ADDR_W-1:PHYS_POS+1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd       <= LC_NONE;
         phys      <= 1'b0;
         line_addr <= '0;
         go        <= 1'b0;
      end else begin
         if (wr_lc) begin
            cmd  <= lcmd_e'(csr_wdata[1:0]);
            phys <= csr_wdata[PHYS_POS];
         end
         if (wr_sa) begin
            line_addr <= csr_wdata[ADDR_W-1:OFF_W];
         end
         if (start) begin
            go <= 1'b1;
         end else if (done) begin
            go <= 1'b0;
         end
      end
   end

   always_comb begin
      csr_rdata = '0;
      if (csr_sel) begin
         csr_rdata[ADDR_W-1:OFF_W] = line_addr;
         csr_rdata[0]              = go;
      end else begin
         csr_rdata[1:0]      = cmd;
         csr_rdata[PHYS_POS] = phys;
      end
   end

   // R3
   go_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !go);

   // R3
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go && !done |=> go && $stable(line_addr));

   // R2
   cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> $stable(cmd) && $stable(phys));

endmodule

// File: rtl/ccm_lookup.sv
module ccm_lookup #(
   parameter int WAYS  = 2,
   parameter int TAG_W = 20,
   parameter int WAY_W = 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      chk_en,
   input  logic [WAYS*(TAG_W+2)-1:0] rd_data,
   input  logic [TAG_W-1:0]          tag,
   output logic                      hit,
   output logic [WAY_W-1:0]          hit_way,
   output logic                      hit_dirty
);
   localparam int ENT_W = TAG_W + 2;

   if (WAYS < 1 || (1 << WAY_W) < WAYS) begin : g_bad_ways
      $error("ccm_lookup: WAY_W cannot index WAYS");
   end

   logic [WAYS-1:0] match;
   logic [WAYS-1:0] dirty;
   logic [WAYS-1:0] grant;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [ENT_W-1:0] ent;
      assign ent      = rd_data[w*ENT_W +: ENT_W];
      assign match[w] = ent[ENT_W-1] && (ent[TAG_W-1:0] == tag);
      assign dirty[w] = ent[ENT_W-2];
   end

   // lowest-numbered matching way wins
   always_comb begin
      grant     = '0;
      hit       = 1'b0;
      hit_way   = '0;
      hit_dirty = 1'b0;
      for (int w = 0; w < WAYS; w++) begin
         if (match[w] && !hit) begin
            hit       = 1'b1;
            grant[w]  = 1'b1;
            hit_way   = WAY_W'(w);
            hit_dirty = dirty[w];
         end
      end
   end

   // R4
   grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chk_en |-> $onehot0(grant) && ((grant & ~match) == '0) && (hit == (match != '0)));

endmodule

// File: rtl/ccm_seq.sv
module ccm_seq
   import ccm_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int OFF_W  = 4,
   parameter int IDX_W  = 8,
   parameter int WAY_W  = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  lcmd_e                 cmd,
   input  logic                  phys,
   input  logic [ADDR_W-1:OFF_W] line_addr,
   input  logic                  hit,
   input  logic [WAY_W-1:0]      hit_way,
   input  logic                  hit_dirty,
   input  logic                  wb_ack,
   output logic                  in_cmp,
   output logic                  tag_rd_en,
   output logic [IDX_W-1:0]      tag_rd_idx,
   output logic                  tag_wr_en,
   output logic [IDX_W-1:0]      tag_wr_idx,
   output logic [WAY_W-1:0]      tag_wr_way,
   output logic                  tag_wr_valid,
   output logic                  tag_wr_dirty,
   output logic                  wb_req,
   output logic [ADDR_W-1:0]     wb_addr,
   output logic [WAY_W-1:0]      wb_way,
   output logic                  done
);
   seq_e             state, nxt;
   act_t             r_act, cur_act;
   logic [WAY_W-1:0] r_way;
   logic             skip;

   assign cur_act = decide(cmd, hit_dirty);
   assign skip    = !phys || !hit || !cur_act.wr;

   always_comb begin
      nxt = state;
      unique case (state)
         S_IDLE: if (start) nxt = S_READ;
         S_READ: nxt = S_CMP;
         S_CMP:  nxt = skip ? S_IDLE : (cur_act.wb ? S_WB : S_UPD);
         S_WB:   if (wb_ack) nxt = S_UPD;
         S_UPD:  nxt = S_IDLE;
         default: nxt = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= S_IDLE;
         r_act <= '0;
         r_way <= '0;
      end else begin
         state <= nxt;
         if (state == S_CMP) begin
            r_act <= cur_act;
            r_way <= hit_way;
         end
      end
   end

   assign in_cmp       = (state == S_CMP);
   assign tag_rd_en    = (state == S_READ);
   assign tag_rd_idx   = line_addr[OFF_W +: IDX_W];
   assign tag_wr_en    = (state == S_UPD);
   assign tag_wr_idx   = line_addr[OFF_W +: IDX_W];
   assign tag_wr_way   = r_way;
   assign tag_wr_valid = r_act.nv;
   assign tag_wr_dirty = r_act.nm;
   assign wb_req       = (state == S_WB);
   assign wb_addr      = {line_addr, {OFF_W{1'b0}}};
   assign wb_way       = r_way;
   assign done         = (state == S_UPD) || (state == S_CMP && skip);

   // R9
   wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_req && !wb_ack |=> wb_req && $stable(wb_addr) && $stable(wb_way));

   // R9
   wb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(tag_wr_en && wb_req));

   // R5
   drop_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tag_wr_en && cmd != LC_PUSH |-> !tag_wr_valid && !tag_wr_dirty);

   // R6
   push_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tag_wr_en && cmd == LC_PUSH |-> tag_wr_valid && !tag_wr_dirty);

   // R8
   quiet_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == LC_NONE || !phys) |-> !tag_wr_en && !wb_req);

endmodule

// File: rtl/ccm_line_maint.sv
module ccm_line_maint
   import ccm_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 16,
   parameter int SETS       = 256,
   parameter int WAYS       = 2,
   localparam int OFF_W     = $clog2(LINE_BYTES),
   localparam int IDX_W     = $clog2(SETS),
   localparam int TAG_W     = ADDR_W - IDX_W - OFF_W,
   localparam int WAY_W     = (WAYS > 1) ? $clog2(WAYS) : 1,
   localparam int ENT_W     = TAG_W + 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  csr_wr,
   input  logic                  csr_sel,
   input  logic [ADDR_W-1:0]     csr_wdata,
   output logic [ADDR_W-1:0]     csr_rdata,
   output logic                  tag_rd_en,
   output logic [IDX_W-1:0]      tag_rd_idx,
   input  logic [WAYS*ENT_W-1:0] tag_rd_data,
   output logic                  tag_wr_en,
   output logic [IDX_W-1:0]      tag_wr_idx,
   output logic [WAY_W-1:0]      tag_wr_way,
   output logic                  tag_wr_valid,
   output logic                  tag_wr_dirty,
   output logic                  wb_req,
   output logic [ADDR_W-1:0]     wb_addr,
   output logic [WAY_W-1:0]      wb_way,
   input  logic                  wb_ack
);
   if ((1 << OFF_W) != LINE_BYTES || (1 << IDX_W) != SETS) begin : g_bad_geom
      $error("ccm_line_maint: LINE_BYTES and SETS must be powers of two");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("ccm_line_maint: no tag bits left");
   end

   lcmd_e                 cmd;
   logic                  phys, go, start, done, in_cmp;
   logic [ADDR_W-1:OFF_W] line_addr;
   logic                  hit, hit_dirty;
   logic [WAY_W-1:0]      hit_way;
   logic                  unused_go;

   assign unused_go = go;

   ccm_regs #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_sel(csr_sel),
      .csr_wdata(csr_wdata), .done(done), .cmd(cmd), .phys(phys),
      .line_addr(line_addr), .go(go), .start(start), .csr_rdata(csr_rdata)
   );

   ccm_lookup #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_lookup (
      .clk(clk), .rst_n(rst_n), .chk_en(in_cmp), .rd_data(tag_rd_data),
      .tag(line_addr[ADDR_W-1:OFF_W+IDX_W]), .hit(hit), .hit_way(hit_way),
      .hit_dirty(hit_dirty)
   );

   ccm_seq #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .WAY_W(WAY_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .phys(phys),
      .line_addr(line_addr), .hit(hit), .hit_way(hit_way), .hit_dirty(hit_dirty),
      .wb_ack(wb_ack), .in_cmp(in_cmp), .tag_rd_en(tag_rd_en), .tag_rd_idx(tag_rd_idx),
      .tag_wr_en(tag_wr_en), .tag_wr_idx(tag_wr_idx), .tag_wr_way(tag_wr_way),
      .tag_wr_valid(tag_wr_valid), .tag_wr_dirty(tag_wr_dirty), .wb_req(wb_req),
      .wb_addr(wb_addr), .wb_way(wb_way), .done(done)
   );

   // R9
   ack_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_req && !wb_ack |=> go);

endmodule

// File: tb/ccm_line_maint_tb.sv
`timescale 1ns/1ps
module ccm_line_maint_tb;
   localparam int SETS = 256, WAYS = 2, ENT_W = 22, ACKDLY = 3;

   typedef struct packed { logic [31:0] addr; logic way; } wb_item_t;
   typedef struct packed { logic [7:0] idx; logic way; logic v; logic m; } tw_item_t;

   logic        clk = 0, rst_n = 0;
   logic        csr_wr = 0, csr_sel = 0, wb_ack = 0;
   logic [31:0] csr_wdata = 0, csr_rdata, wb_addr;
   logic        tag_rd_en, tag_wr_en, tag_wr_way, tag_wr_valid, tag_wr_dirty, wb_req, wb_way;
   logic [7:0]  tag_rd_idx, tag_wr_idx;
   logic [WAYS*ENT_W-1:0] tag_rd_data;

   logic [ENT_W-1:0] mem [0:SETS-1][0:WAYS-1];
   wb_item_t wbq[$];
   tw_item_t twq[$];
   int n_vec = 0, n_bad = 0;
   bit finished = 0, wb_seen = 0;
   int wait_cnt = 0;

   always #2 clk = ~clk;

   ccm_line_maint u_dut (
      .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_sel(csr_sel), .csr_wdata(csr_wdata),
      .csr_rdata(csr_rdata), .tag_rd_en(tag_rd_en), .tag_rd_idx(tag_rd_idx),
      .tag_rd_data(tag_rd_data), .tag_wr_en(tag_wr_en), .tag_wr_idx(tag_wr_idx),
      .tag_wr_way(tag_wr_way), .tag_wr_valid(tag_wr_valid), .tag_wr_dirty(tag_wr_dirty),
      .wb_req(wb_req), .wb_addr(wb_addr), .wb_way(wb_way), .wb_ack(wb_ack)
   );

   // tag store model: synchronous read, write on update
   always @(posedge clk) begin
      if (tag_rd_en)
         for (int w = 0; w < WAYS; w++) tag_rd_data[w*ENT_W +: ENT_W] <= mem[tag_rd_idx][w];
      if (tag_wr_en) mem[tag_wr_idx][tag_wr_way] <= {tag_wr_valid, tag_wr_dirty, mem[tag_wr_idx][tag_wr_way][19:0]};
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // write-back monitor and acknowledge responder (R9)
   initial forever begin
      @(negedge clk);
      if (wb_ack) wb_ack = 0;
      else if (wb_req) begin
         if (!wb_seen) begin
            wb_seen = 1; wait_cnt = 0;
            if (wbq.size() == 0) chk(0, "R9", "unexpected write-back", {31'b0, wb_way, wb_addr}, 0);
            else begin
               wb_item_t e;
               e = wbq.pop_front();
               chk({wb_addr, wb_way} == {e.addr, e.way}, "R9", "write-back addr/way",
                   {31'b0, wb_way, wb_addr}, {31'b0, e.way, e.addr});
            end
         end else if (wait_cnt == ACKDLY) begin
            chk(tag_wr_en == 0, "R9", "tag write before ack", {63'b0, tag_wr_en}, 0);
            wb_ack = 1; wb_seen = 0;
         end else wait_cnt++;
      end
   end

   // tag write monitor
   initial forever begin
      @(negedge clk);
      if (tag_wr_en) begin
         if (twq.size() == 0)
            chk(0, "R8", "unexpected tag write", {52'b0, tag_wr_idx, tag_wr_way, tag_wr_valid, tag_wr_dirty}, 0);
         else begin
            tw_item_t e;
            e = twq.pop_front();
            chk({tag_wr_idx, tag_wr_way, tag_wr_valid, tag_wr_dirty} == e, "R4", "tag write idx/way/v/m",
                {53'b0, tag_wr_idx, tag_wr_way, tag_wr_valid, tag_wr_dirty}, {53'b0, e});
         end
      end
   end

   task automatic wr_csr(input logic sel, input logic [31:0] d);
      @(negedge clk); csr_wr = 1; csr_sel = sel; csr_wdata = d;
      @(negedge clk); csr_wr = 0;
   endtask

   task automatic rd_csr(input logic sel, output logic [31:0] v);
      @(negedge clk); csr_sel = sel; #1; v = csr_rdata;
   endtask

   task automatic run_cmd(input logic [1:0] c, input bit ph, input logic [31:0] a,
                          input bit poke, input string req);
      logic [7:0] idx; logic [19:0] tg; bit hit; int hw; logic [ENT_W-1:0] ex [0:WAYS-1];
      logic [31:0] v; int n;
      idx = a[11:4]; tg = a[31:12]; hit = 0; hw = 0;
      for (int w = 0; w < WAYS; w++) begin
         ex[w] = mem[idx][w];
         if (!hit && mem[idx][w][21] && mem[idx][w][19:0] == tg) begin hit = 1; hw = w; end
      end
      if (ph && hit && c != 2'd0) begin
         if (c != 2'd1 && ex[hw][20]) wbq.push_back('{addr: {a[31:4], 4'b0}, way: 1'(hw)});
         twq.push_back('{idx: idx, way: 1'(hw), v: (c == 2'd2), m: 1'b0});
         ex[hw][21] = (c == 2'd2); ex[hw][20] = 1'b0;
      end
      wr_csr(0, {23'b0, ph, 6'b0, c});
      wr_csr(1, a | 32'h1);
      rd_csr(1, v);
      chk(v[0] == 1, "R3", "start bit set while busy", {63'b0, v[0]}, 1);
      if (poke) wr_csr(1, ~a | 32'h1);
      n = 0;
      do begin rd_csr(1, v); n++; end while (v[0] && n < 200);
      chk(v[0] == 0, "R3", "start bit self-clears", {63'b0, v[0]}, 0);
      chk(v == {a[31:4], 4'b0}, "R3", "address readback aligned", {32'b0, v}, {32'b0, a[31:4], 4'b0});
      chk(wbq.size() == 0 && twq.size() == 0, req, "missing write-back or tag write",
          64'(wbq.size() + twq.size()), 0);
      @(negedge clk);
      for (int w = 0; w < WAYS; w++)
         chk(mem[idx][w] == ex[w], req, $sformatf("entry way %0d", w), {42'b0, mem[idx][w]}, {42'b0, ex[w]});
   endtask

   initial begin
      repeat (40000) @(posedge clk);
      if (!finished) begin
         finished = 1; n_vec++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      for (int s = 0; s < SETS; s++) for (int w = 0; w < WAYS; w++) mem[s][w] = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      rd_csr(0, v); chk(v == 0, "R1", "line-command reset", {32'b0, v}, 0);
      rd_csr(1, v); chk(v == 0, "R1", "search-address reset", {32'b0, v}, 0);
      chk({wb_req, tag_wr_en, tag_rd_en} == 0, "R1", "idle strobes", {61'b0, wb_req, tag_wr_en, tag_rd_en}, 0);
      rst_n = 1;
      // R2 register layout
      wr_csr(0, 32'hFFFF_FE02 | 32'h100);
      rd_csr(0, v); chk(v == 32'h102, "R2", "line-command readback", {32'b0, v}, 32'h102);

      mem[8'h12][0] = {1'b1, 1'b1, 20'hABCDE};
      mem[8'h12][1] = {1'b1, 1'b1, 20'h11111};
      // R6 push dirty, junk offset bits, busy write ignored (R3)
      run_cmd(2'd2, 1, 32'hABCDE127, 1, "R6");
      rd_csr(0, v); chk(v == 32'h102, "R2", "command persists", {32'b0, v}, 32'h102);
      // R6 push clean
      run_cmd(2'd2, 1, 32'hABCDE120, 0, "R6");
      // R5 invalidate dirty line in way 1 (R4 both ways)
      run_cmd(2'd1, 1, 32'h11111120, 0, "R5");
      // R7 clear dirty, clear clean
      mem[8'h40][1] = {1'b1, 1'b1, 20'h0F0F0};
      run_cmd(2'd3, 1, 32'h0F0F0400, 0, "R7");
      mem[8'h41][0] = {1'b1, 1'b0, 20'h22222};
      run_cmd(2'd3, 1, 32'h22222410, 0, "R7");
      // R8 miss, code 0, physical flag 0
      mem[8'h50][0] = {1'b1, 1'b1, 20'h33333};
      run_cmd(2'd1, 1, 32'h44444500, 0, "R8");
      run_cmd(2'd0, 1, 32'h33333500, 0, "R8");
      run_cmd(2'd1, 0, 32'h33333500, 0, "R8");
      // R4 both ways match: way 0 wins
      mem[8'h60][0] = {1'b1, 1'b1, 20'h55555};
      mem[8'h60][1] = {1'b1, 1'b1, 20'h55555};
      run_cmd(2'd3, 1, 32'h55555600, 0, "R4");
      // R4 invalid entry with equal tag is a miss
      mem[8'h61][1] = {1'b0, 1'b1, 20'h66666};
      run_cmd(2'd1, 1, 32'h66666610, 0, "R4");
      // R9 top index and tag, push dirty in way 1
      mem[8'hFF][1] = {1'b1, 1'b1, 20'hFFFFF};
      run_cmd(2'd2, 1, 32'hFFFFFFFF, 0, "R9");

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule